// File: doc/BRIEF.md
# Axis Counter Status Flag Register

This block keeps the eight-bit status word for one axis of an up/down position counter. Event pulses come from the counter (underflow and overflow), from the preset comparator (equality level), from the quadrature decoder (direction level and filter error pulse) and from the index input. The block turns these into three toggle flags, a sign flag, a direction flag and two latched flags. It presents them as one registered byte for the data bus.

The borrow, carry and compare flags flip on each qualifying event rather than staying set. Software can therefore detect an event by comparing two reads. The sign flag records which end the counter last wrapped through. The error and index flags hold once set. Two separate clear commands reset them: one command resets the dynamic group together with the index flag, and the other resets only the error flag. Every bit updates on the clock edge at which its inputs are sampled, so the byte lags its inputs by one cycle.

Top module: `axis_status_flags`

## Requirements
- R1: After reset is asserted, `flag_byte` reads 0x00.
- R2: Bit 0 (borrow) inverts on each clock edge where `cnt_underflow` is 1 and `clr_status` is 0.
- R3: Bit 1 (carry) inverts on each clock edge where `cnt_overflow` is 1 and `clr_status` is 0.
- R4: Bit 2 (compare) inverts once per rising transition of `cmp_equal`: a sampled 1 whose previous sample was 0, or the first sampled 1 after reset. It does not invert again while `cmp_equal` stays 1.
- R5: Bit 3 (sign) becomes 1 on an underflow without an overflow, and 0 on an overflow without an underflow. It holds when both or neither occur.
- R6: Bit 5 (direction) equals the value of `count_up` sampled at the previous clock edge.
- R7: Bit 4 (error) becomes 1 when `quad_error` is sampled high and holds until `clr_error` is sampled. If both are high on the same edge, the bit becomes 1.
- R8: Bit 6 (index) becomes 1 when `index_event` is sampled high and holds until `clr_status` is sampled. If both are high on the same edge, the bit becomes 1.
- R9: `clr_status` forces bits 0 to 3 to 0 and takes priority over their events. It leaves bits 4 and 5 unchanged. `clr_error` changes only bit 4.
- R10: Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_underflow | input | 1 | Counter wrapped downward this cycle |
| cnt_overflow | input | 1 | Counter wrapped upward this cycle |
| cmp_equal | input | 1 | Counter equals preset (level) |
| count_up | input | 1 | Current count direction, 1 = up |
| quad_error | input | 1 | Quadrature filter error pulse |
| index_event | input | 1 | Index input reached its active level |
| clr_status | input | 1 | Clear borrow, carry, compare, sign and index |
| clr_error | input | 1 | Clear the error flag |
| flag_byte | output | 8 | Status word |

## Verification
The bench builds the block with its defaults: the compare flag is driven from a rising-transition detector, and the direction bit resets to 0. With eight single-bit inputs there are only 256 input combinations. The bench drives every combination in four different orders, so each combination is applied from many different flag states. This covers the same-cycle conflicts between clears and set events, as well as simultaneous underflow and overflow. Directed sequences add a long stretch of held equality and an error flag that outlives repeated status clears.

// File: rtl/axis_flag_pkg.sv
package axis_flag_pkg;
   localparam int unsigned FLAG_W  = 8;
   localparam int unsigned BIT_BT  = 0;
   localparam int unsigned BIT_CT  = 1;
   localparam int unsigned BIT_CPT = 2;
   localparam int unsigned BIT_SGN = 3;
   localparam int unsigned BIT_ERR = 4;
   localparam int unsigned BIT_DIR = 5;
   localparam int unsigned BIT_IDX = 6;
   localparam int unsigned BIT_NU  = 7;
   localparam int unsigned N_TOG   = 3;

   typedef enum logic {CMP_ENTRY = 1'b0, CMP_PULSE = 1'b1} cmp_mode_e;
endpackage

// File: rtl/flag_toggle_bit.sv
module flag_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (evt) q <= ~q;
   end
endmodule

// File: rtl/flag_latch_bit.sv
module flag_latch_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen
   import axis_flag_pkg::*;
#(
   parameter cmp_mode_e MODE = CMP_ENTRY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eq_in,
   output logic evt
);
   generate
      if (MODE == CMP_ENTRY) begin : g_entry
         logic eq_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eq_d <= 1'b0;
            else        eq_d <= eq_in;
         end
         assign evt = eq_in & ~eq_d;
      end else begin : g_pulse
         assign evt = eq_in;
      end
   endgenerate
endmodule

// File: rtl/axis_status_flags.sv
module axis_status_flags
   import axis_flag_pkg::*;
#(
   parameter cmp_mode_e CMP_MODE  = CMP_ENTRY,
   parameter bit        DIR_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_underflow,
   input  logic              cnt_overflow,
   input  logic              cmp_equal,
   input  logic              count_up,
   input  logic              quad_error,
   input  logic              index_event,
   input  logic              clr_status,
   input  logic              clr_error,
   output logic [FLAG_W-1:0] flag_byte
);
   generate
      if (FLAG_W != 8) begin : g_bad_width
         $error("status word must be eight bits wide");
      end
   endgenerate

   logic             cmp_evt;
   logic [N_TOG-1:0] tog_evt;
   logic [N_TOG-1:0] tog_q;
   logic             sign_q;
   logic             dir_q;
   logic             err_q;
   logic             idx_q;

   cmp_event_gen #(.MODE(CMP_MODE)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .eq_in (cmp_equal),
      .evt   (cmp_evt)
   );

   assign tog_evt = {cmp_evt, cnt_overflow, cnt_underflow};

   generate
      for (genvar i = 0; i < N_TOG; i++) begin : g_tog
         flag_toggle_bit u_tog (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (tog_evt[i]),
            .clr   (clr_status),
            .q     (tog_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           sign_q <= 1'b0;
      else if (clr_status)                  sign_q <= 1'b0;
      else if (cnt_underflow & ~cnt_overflow) sign_q <= 1'b1;
      else if (cnt_overflow & ~cnt_underflow) sign_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= DIR_RESET;
      else        dir_q <= count_up;
   end

   flag_latch_bit u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (quad_error),
      .clr   (clr_error),
      .q     (err_q)
   );

   flag_latch_bit u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (index_event),
      .clr   (clr_status),
      .q     (idx_q)
   );

   always_comb begin
      flag_byte          = '0;
      flag_byte[BIT_BT]  = tog_q[0];
      flag_byte[BIT_CT]  = tog_q[1];
      flag_byte[BIT_CPT] = tog_q[2];
      flag_byte[BIT_SGN] = sign_q;
      flag_byte[BIT_ERR] = err_q;
      flag_byte[BIT_DIR] = dir_q;
      flag_byte[BIT_IDX] = idx_q;
      flag_byte[BIT_NU]  = 1'b0;
   end
endmodule

// File: rtl/axis_status_flags_chk.sv
module axis_status_flags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnt_underflow,
   input logic       cnt_overflow,
   input logic       count_up,
   input logic       quad_error,
   input logic       index_event,
   input logic       clr_status,
   input logic       clr_error,
   input logic [7:0] flag_byte
);
   a_r2_borrow_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_underflow && !clr_status) |=> flag_byte[0] != $past(flag_byte[0]));
   a_r3_carry_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_overflow && !clr_status) |=> flag_byte[1] != $past(flag_byte[1]));
   a_r5_sign_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_underflow && !cnt_overflow && !clr_status) |=> flag_byte[3]);
   a_r6_dir_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> flag_byte[5] == $past(count_up));
   a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      quad_error |=> flag_byte[4]);
   a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!quad_error && !clr_error) |=> flag_byte[4] == $past(flag_byte[4]));
   a_r8_idx_set: assert property (@(posedge clk) disable iff (!rst_n)
      index_event |=> flag_byte[6]);
   a_r9_clear_group: assert property (@(posedge clk) disable iff (!rst_n)
      clr_status |=> flag_byte[3:0] == 4'b0000);
   a_r10_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flag_byte[7] == 1'b0);
endmodule

bind axis_status_flags axis_status_flags_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cnt_underflow (cnt_underflow),
   .cnt_overflow  (cnt_overflow),
   .count_up      (count_up),
   .quad_error    (quad_error),
   .index_event   (index_event),
   .clr_status    (clr_status),
   .clr_error     (clr_error),
   .flag_byte     (flag_byte)
);

// File: tb/test_axis_status_flags.sv
`timescale 1ns/1ps
module test_axis_status_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       udf = 0, ovf = 0, cmp = 0, dir = 0, err = 0, idx = 0, clrs = 0, clre = 0;
   logic [7:0] flag_byte;
   int         total = 0;
   int         bad = 0;
   bit         done = 0;

   logic m_bt, m_ct, m_cpt, m_sg, m_er, m_ud, m_ix, m_prev;

   always #2.5 clk = ~clk;

   axis_status_flags i_axis_status_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_underflow (udf),
      .cnt_overflow  (ovf),
      .cmp_equal     (cmp),
      .count_up      (dir),
      .quad_error    (err),
      .index_event   (idx),
      .clr_status    (clrs),
      .clr_error     (clre),
      .flag_byte     (flag_byte)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2 borrow", flag_byte[0], m_bt);
      chk("R3 carry", flag_byte[1], m_ct);
      chk("R4 compare", flag_byte[2], m_cpt);
      chk("R5 sign", flag_byte[3], m_sg);
      chk("R7 error", flag_byte[4], m_er);
      chk("R6 direction", flag_byte[5], m_ud);
      chk("R8 index", flag_byte[6], m_ix);
      chk("R10 unused", flag_byte[7], 1'b0);
   endtask

   // v: [0]udf [1]ovf [2]cmp [3]dir [4]err [5]idx [6]clr_status [7]clr_error
   task automatic step(input logic [7:0] v);
      logic entry;
      {clre, clrs, idx, err, dir, cmp, ovf, udf} = v;
      @(posedge clk);
      @(negedge clk);
      entry  = v[2] & ~m_prev;
      m_prev = v[2];
      // R9: clear takes priority for the dynamic group
      if (v[6]) begin
         m_bt = 0; m_ct = 0; m_cpt = 0; m_sg = 0;
      end else begin
         if (v[0]) m_bt = ~m_bt;
         if (v[1]) m_ct = ~m_ct;
         if (entry) m_cpt = ~m_cpt;
         if (v[0] && !v[1]) m_sg = 1;
         else if (v[1] && !v[0]) m_sg = 0;
      end
      m_ud = v[3];
      if (v[4]) m_er = 1; else if (v[7]) m_er = 0;
      if (v[5]) m_ix = 1; else if (v[6]) m_ix = 0;
      check_all();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_bt = 0; m_ct = 0; m_cpt = 0; m_sg = 0; m_er = 0; m_ud = 0; m_ix = 0; m_prev = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset", flag_byte == 8'h00, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: held equality toggles once only
      step(8'h04); step(8'h04); step(8'h04); step(8'h04);
      step(8'h00); step(8'h04); step(8'h04);
      // R7/R9: error survives status clears, index does not
      step(8'h30); step(8'h40); step(8'h40);
      chk("R9 err kept", flag_byte[4], 1'b1);
      chk("R9 idx cleared", flag_byte[6], 1'b0);
      step(8'h80);
      chk("R7 err cleared", flag_byte[4], 1'b0);
      // R7/R8 set wins
      step(8'h90); step(8'h60);
      // R2/R3/R5 repeated wraps
      step(8'h01); step(8'h01); step(8'h01); step(8'h02); step(8'h03); step(8'h08);

      // near-exhaustive sweep: all 256 combinations in four orders
      for (int pass = 0; pass < 4; pass++) begin
         for (int k = 0; k < 256; k++) begin
            step(8'((k * 167 + pass * 53) % 256));
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule